// File: doc/BRIEF.md
# Banked Character Stream Stack

This block stores the character streams that feed a text interpreter. It holds sixteen banks of 8-bit characters and keeps a single position pointer that all banks share. A bank select decides which bank is the active stream. Reads return the character at the pointer and then advance the pointer. Writes store a character at the pointer and then advance it. A clear command brings the pointer back to zero.

Bank 0 is the interactive stream and is filled from keyboard entry. Banks 1 to 15 hold stored program threads, and each thread begins at position zero. A jump between threads is a single cycle that selects the target bank and clears the pointer. If a read is issued in that same cycle, it already returns the first character of the new thread.

The same write port loads all banks. The bank being written is the selected one. The pointer has six bits by default, so each bank holds 64 entries, and it wraps from the last entry back to zero.

Top module: `stream_stack`

## Requirements
- R1: After reset the selected bank is 0, the pointer is 0 and `rdValid` is low.
- R2: When `selEn` is high at a clock edge, `curBank` takes the value of `selBank` after that edge.
- R3: When `clrPtr` is high, the pointer counts as 0 for that cycle. With no read or write in the same cycle, `curPtr` is 0 after the edge.
- R4: A read (`rdEn` high) presents, one cycle later with `rdValid` high, the entry of the effective bank at the effective pointer on `rdData`. The pointer advances by one.
- R5: A write (`wrEn` high, `rdEn` low) stores `wrData` into the effective bank at the effective pointer. The pointer advances by one.
- R6: A bank select and a pointer clear in the same cycle as a read or write take effect before that access. Selecting a bank, clearing, and reading in one cycle returns entry 0 of the new bank, and `curPtr` becomes 1.
- R7: All banks share one pointer: a bank select alone leaves `curPtr` unchanged.
- R8: When the pointer is at its last value (63 by default), an access wraps it to 0.
- R9: When `rdEn` and `wrEn` are both high, the read takes place and the write is dropped. The addressed entry keeps its old value.
- R10: In a cycle with no command, `curBank` and `curPtr` hold their values and `rdValid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selEn | input | 1 | Load a new active bank |
| selBank | input | 4 | Bank number to select |
| clrPtr | input | 1 | Clear the shared pointer |
| rdEn | input | 1 | Read at the pointer, then advance |
| wrEn | input | 1 | Write at the pointer, then advance |
| wrData | input | DATA_W | Character to write |
| rdData | output | DATA_W | Character read in the previous cycle |
| rdValid | output | 1 | `rdData` holds a fresh read |
| curBank | output | 4 | Active bank |
| curPtr | output | 6 | Shared pointer |

## Verification
A wrong pointer or bank register appears on `curPtr` or `curBank` in the cycle after the faulty update, because both are compared against the model on every clock. A wrong address or a wrong ordering between select, clear and access does not show at once. It appears in `rdData` only when the corrupted or misplaced entry is read back. For that reason the stimulus reads back every thread it writes, including across a pointer wrap and after a jump. A dropped or spurious write shows in the first later read of that entry.

// File: rtl/stream_stack_pkg.sv
package stream_stack_pkg;
  localparam int BANK_W  = 4;
  localparam int PTR_W   = 6;
  localparam int NBANKS  = 1 << BANK_W;
  localparam int ENTRIES = 1 << PTR_W;

  typedef struct packed {
    logic              doRd;
    logic              doWr;
    logic [BANK_W-1:0] bank;
    logic [PTR_W-1:0]  ptr;
  } accessStrb_t;
endpackage

// File: rtl/stream_stack_ctrl.sv
module stream_stack_ctrl
  import stream_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selEn,
  input  logic [BANK_W-1:0] selBank,
  input  logic              clrPtr,
  input  logic              rdEn,
  input  logic              wrEn,
  output accessStrb_t       strb,
  output logic [BANK_W-1:0] bankQ,
  output logic [PTR_W-1:0]  ptrQ
);
  logic [BANK_W-1:0] effBank;
  logic [PTR_W-1:0]  effPtr;
  logic [PTR_W-1:0]  ptrNext;
  logic              anyAccess;

  always_comb begin
    effBank   = selEn  ? selBank : bankQ;
    effPtr    = clrPtr ? '0 : ptrQ;
    anyAccess = rdEn | wrEn;
    ptrNext   = anyAccess ? effPtr + 1'b1 : effPtr;
    strb.doRd = rdEn;
    strb.doWr = wrEn & ~rdEn;
    strb.bank = effBank;
    strb.ptr  = effPtr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bankQ <= '0;
      ptrQ  <= '0;
    end else begin
      bankQ <= effBank;
      ptrQ  <= ptrNext;
    end
  end

  assert_sel_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    selEn |=> bankQ == $past(selBank));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clrPtr && !rdEn && !wrEn) |=> ptrQ == '0);

  assert_jump_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clrPtr && rdEn) |=> ptrQ == PTR_W'(1));

  assert_shared_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (selEn && !clrPtr && !rdEn && !wrEn) |=> $stable(ptrQ));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrPtr && (rdEn || wrEn) && ptrQ == PTR_W'(ENTRIES-1)) |=> ptrQ == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!selEn && !clrPtr && !rdEn && !wrEn) |=> ($stable(ptrQ) && $stable(bankQ)));
endmodule

// File: rtl/stream_stack_dp.sv
module stream_stack_dp
  import stream_stack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  accessStrb_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH  = NBANKS * ENTRIES;
  localparam int ADDR_W = BANK_W + PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  assign addr = {strb.bank, strb.ptr};

  always_ff @(posedge clk) begin
    if (strb.doWr) mem[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.doRd;
      if (strb.doRd) rdData <= mem[addr];
    end
  end

  assert_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doRd |=> rdValid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.doRd |=> !rdValid);

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.doRd |=> $stable(rdData));
endmodule

// File: rtl/stream_stack.sv
module stream_stack
  import stream_stack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selEn,
  input  logic [BANK_W-1:0] selBank,
  input  logic              clrPtr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [BANK_W-1:0] curBank,
  output logic [PTR_W-1:0]  curPtr
);
  accessStrb_t strb;

  stream_stack_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .selEn   (selEn),
    .selBank (selBank),
    .clrPtr  (clrPtr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .strb    (strb),
    .bankQ   (curBank),
    .ptrQ    (curPtr)
  );

  stream_stack_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: tb/stream_stack_tb.sv
module stream_stack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       selEn = 1'b0;
  logic [3:0] selBank = '0;
  logic       clrPtr = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic [3:0] curBank;
  logic [5:0] curPtr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mMem [16][64];
  bit         mKnown [16][64];
  int         mBank = 0;
  int         mPtr = 0;
  bit         mRdV = 0;
  bit         mRdKnown = 0;
  logic [7:0] mRdData = '0;

  always #4 clk = ~clk;

  stream_stack u_dut (
    .clk(clk), .rst_n(rst_n), .selEn(selEn), .selBank(selBank), .clrPtr(clrPtr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .curBank(curBank), .curPtr(curPtr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(curBank == 4'(mBank), {tag, " bank"}, int'(curBank), mBank);
    check(curPtr == 6'(mPtr), {tag, " ptr"}, int'(curPtr), mPtr);
    check(rdValid == mRdV, {tag, " valid"}, int'(rdValid), int'(mRdV));
    if (mRdV && mRdKnown)
      check(rdData == mRdData, {tag, " data"}, int'(rdData), int'(mRdData));
  endtask

  task automatic step(input bit s, input int sb, input bit c, input bit r,
                      input bit w, input int wd, input string tag);
    int eb;
    int ep;
    selEn = s; selBank = 4'(sb); clrPtr = c; rdEn = r; wrEn = w; wrData = 8'(wd);
    @(posedge clk);
    eb = s ? sb : mBank;
    ep = c ? 0 : mPtr;
    mRdV = r;
    if (r) begin
      mRdKnown = mKnown[eb][ep];
      mRdData  = mMem[eb][ep];
    end else if (w) begin
      mMem[eb][ep]   = 8'(wd);
      mKnown[eb][ep] = 1'b1;
    end
    if (r || w) ep = (ep + 1) % 64;
    mBank = eb;
    mPtr  = ep;
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1 reset");
    // R5: keyboard text into bank 0
    step(0, 0, 0, 0, 1, "K", "R5 wr");
    step(0, 0, 0, 0, 1, "E", "R5 wr");
    step(0, 0, 0, 0, 1, "Y", "R5 wr");
    // R3: clear alone
    step(0, 0, 1, 0, 0, 0, "R3 clear");
    // R4: read back
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R4 read");
    step(0, 0, 0, 0, 0, 0, "R10 idle");
    step(0, 0, 0, 0, 0, 0, "R10 idle");
    // R2 and R7: select bank 3, pointer kept
    step(1, 3, 0, 0, 0, 0, "R2 R7 select");
    // R6: select plus clear plus write lands at entry 0 of bank 5
    step(1, 5, 1, 0, 1, 8'h41, "R6 sel clr wr");
    for (int i = 1; i < 6; i++) step(0, 0, 0, 0, 1, 8'h41 + i, "R5 thread");
    step(1, 0, 0, 0, 0, 0, "R7 select back");
    // R6: jump to bank 5 and read its first character in one cycle
    step(1, 5, 1, 1, 0, 0, "R6 jump read");
    step(0, 0, 0, 1, 0, 0, "R4 next");
    // R9: read and write together, write dropped
    step(0, 0, 0, 1, 1, 8'hEE, "R9 rd wr");
    step(0, 0, 1, 0, 0, 0, "R3 clear");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, "R9 readback");
    // R8: fill bank 15 completely, pointer wraps
    step(1, 15, 1, 0, 1, 0, "R6 fill start");
    for (int i = 1; i < 64; i++) step(0, 0, 0, 0, 1, (i * 7) & 255, "R8 fill");
    check(curPtr == 6'd0, "R8 wrap", int'(curPtr), 0);
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 0, 0, "R8 read");
    step(1, 0, 1, 1, 0, 0, "R6 back to keyboard");
    step(0, 0, 0, 0, 0, 0, "R10 idle");
    // R1: reset again
    rst_n = 1'b0;
    @(posedge clk);
    mBank = 0; mPtr = 0; mRdV = 0;
    @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1 reset again");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule